// File: doc/BRIEF.md
# Clocked Single-Wire Frame Receiver with Break Classification

This block is the receive half of a half-duplex serial link that has its own link clock. On every rising edge of that clock it samples the shared data wire. While idle it waits for a low start bit. It then collects eight data bits (least significant first), one even-parity bit and two stop bits, so a frame lasts 12 link clocks. Once the last stop bit has been sampled, it reports the outcome to the controller above it as a set of one-cycle pulses.

A frame whose parity and stop bits are both correct delivers its byte together with a valid pulse. A parity mismatch and a low stop bit are reported as two separate error flags, and both can fire for the same frame. A frame whose 12 samples are all low is a break. A direction input says whether the link is driving the wire at that moment. In receive mode a break is reported as a break. In transmit mode it is reported as a collision. A second break that follows an earlier break or collision is always reported as a break, whatever the direction. The high gap between the two is guaranteed, because the receiver always waits for the wire to go high after a frame.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rxData is 0 and rxValid, parityErr, frameErr, breakDet and collision are all 0.
- R2: A frame begins with a low sample taken while the receiver is idle. A high idle line produces no pulse. The outcome pulses appear in the cycle after the edge that samples the 12th frame bit (the second stop bit), and never before it.
- R3: Data bits arrive least significant first. When the frame is good, rxData carries the byte and rxValid pulses for exactly one cycle.
- R4: Parity is even: the parity bit must equal the XOR of the eight data bits. A mismatch pulses parityErr and suppresses rxValid, and rxData keeps its previous value.
- R5: A low first or second stop bit pulses frameErr and suppresses rxValid. rxData keeps its previous value.
- R6: The parity and stop checks are independent. A frame that fails both pulses parityErr and frameErr in the same cycle.
- R7: A frame whose 12 samples are all low is a break. It pulses exactly one of breakDet or collision and never parityErr, frameErr or rxValid. In receive mode (txMode = 0) it pulses breakDet. A frame of zero data that has a high stop bit is an ordinary frame error, not a break.
- R8: A break in transmit mode (txMode = 1, sampled with the last bit) pulses collision and not breakDet, unless R9 applies.
- R9: A break whose previous completed frame was also a break (reported either way) pulses breakDet in either mode. Any completed non-break frame clears this condition.
- R10: After a frame, a new start bit is accepted only after the line has been sampled high. A low line lasting longer than 12 bits produces only one break indication.
- R11: When the second stop bit is high, the very next low sample is taken as a new start bit, so frames may follow each other with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock; the line is sampled on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Serial data wire |
| txMode | input | 1 | 1 while the link is in its transmit direction |
| rxData | output | 8 | Last correctly received byte |
| rxValid | output | 1 | One-cycle pulse: rxData holds a new byte |
| parityErr | output | 1 | One-cycle pulse: parity mismatch |
| frameErr | output | 1 | One-cycle pulse: a stop bit was low |
| breakDet | output | 1 | One-cycle pulse: break recognised |
| collision | output | 1 | One-cycle pulse: break seen while transmitting |

## Verification
Each kind of internal fault shows up at the ports within one frame.
- A bit counter that slips moves the outcome pulse off the 12th-bit boundary. It also shifts the sampled bits, which shows as a wrong byte, a false parity error or a false frame error in that same frame.
- A stale all-low tracker turns a zero-data frame error into a break, or the reverse.
- A lost or sticky break-history flag shows on the next break: it arrives as a collision when a break was due, or the other way round.
- A receiver that skips the wait-for-high state raises a second break during a long low line, within 12 clocks of the first.

// File: rtl/serial_frame_rx_pkg.sv
`timescale 1ns/1ps
package serial_frame_rx_pkg;

  // Strobes from the sequencer to the datapath; at most one of the first four per cycle
  typedef struct packed {
    logic startFrame;   // low start bit accepted in idle
    logic shiftData;    // current sample is a data bit
    logic takeParity;   // current sample is the parity bit
    logic takeStop;     // current sample is a stop bit
    logic lastBit;      // current sample is the final stop bit
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAITHIGH
  } rxState_t;

endpackage

// File: rtl/serial_frame_rx_ctrl.sv
`timescale 1ns/1ps
module serial_frame_rx_ctrl
  import serial_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lineIn,
  output rxStrobes_t strobes
);

  localparam int MAX_CNT = (DATA_BITS > STOP_BITS) ? DATA_BITS : STOP_BITS;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_STOP = CNT_W'(STOP_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_IDLE:   strobes.startFrame = ~lineIn;
      ST_DATA:   strobes.shiftData  = 1'b1;
      ST_PARITY: strobes.takeParity = 1'b1;
      ST_STOP: begin
        strobes.takeStop = 1'b1;
        strobes.lastBit  = (bitCnt == LAST_STOP);
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (!lineIn) state <= ST_DATA;
        end
        ST_DATA: begin
          if (bitCnt == LAST_DATA) begin
            bitCnt <= '0;
            state  <= ST_PARITY;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          bitCnt <= '0;
          state  <= ST_STOP;
        end
        ST_STOP: begin
          if (bitCnt == LAST_STOP) begin
            bitCnt <= '0;
            state  <= lineIn ? ST_IDLE : ST_WAITHIGH;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WAITHIGH: begin
          bitCnt <= '0;
          if (lineIn) state <= ST_IDLE;
        end
        default: begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end
      endcase
    end
  end

  // R10
  no_restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.lastBit && !lineIn) |=> !strobes.startFrame);

  // R2
  start_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startFrame |=> strobes.shiftData);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.startFrame, strobes.shiftData, strobes.takeParity, strobes.takeStop}));

  // R11
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.lastBit && lineIn) |=> (strobes.startFrame == !lineIn));

endmodule

// File: rtl/serial_frame_rx_dp.sv
`timescale 1ns/1ps
module serial_frame_rx_dp
  import serial_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lineIn,
  input  logic                 txMode,
  input  rxStrobes_t           strobes,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 collision
);

  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] nextShift;
  logic                 parityAcc;
  logic                 allLow;
  logic                 stopOk;
  logic                 armed;     // previous completed frame was a break

  logic lowFinal, stopFinal, isBreak, parFail;

  always_comb begin
    nextShift = shiftReg >> 1;
    nextShift[DATA_BITS-1] = lineIn;
  end

  assign lowFinal  = allLow & ~lineIn;
  assign stopFinal = stopOk & lineIn;
  assign isBreak   = lowFinal;
  assign parFail   = parityAcc;   // data and parity bit already folded in

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      parityAcc <= 1'b0;
      allLow    <= 1'b0;
      stopOk    <= 1'b0;
      armed     <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
      collision <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
      collision <= 1'b0;

      if (strobes.startFrame) begin
        shiftReg  <= '0;
        parityAcc <= 1'b0;
        allLow    <= 1'b1;
        stopOk    <= 1'b1;
      end

      if (strobes.shiftData) begin
        shiftReg  <= nextShift;
        parityAcc <= parityAcc ^ lineIn;
        allLow    <= allLow & ~lineIn;
      end

      if (strobes.takeParity) begin
        parityAcc <= parityAcc ^ lineIn;
        allLow    <= allLow & ~lineIn;
      end

      if (strobes.takeStop && !strobes.lastBit) begin
        stopOk <= stopOk & lineIn;
        allLow <= allLow & ~lineIn;
      end

      if (strobes.lastBit) begin
        armed <= isBreak;
        if (isBreak) begin
          breakDet  <= ~txMode | armed;
          collision <= txMode & ~armed;
        end else begin
          parityErr <= parFail;
          frameErr  <= ~stopFinal;
          if (stopFinal && !parFail) begin
            rxValid <= 1'b1;
            rxData  <= shiftReg;
          end
        end
      end
    end
  end

  // R3
  valid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> !(parityErr || frameErr || breakDet || collision));

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValid |-> $stable(rxData));

  // R7
  break_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (breakDet || collision) |-> !(parityErr || frameErr || rxValid));

  // R7
  break_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({breakDet, collision}));

  // R8
  collision_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> $past(txMode));

  // R9
  second_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (breakDet && $past(txMode)) |-> $past(armed));

endmodule

// File: rtl/serial_frame_rx.sv
`timescale 1ns/1ps
module serial_frame_rx
  import serial_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lineIn,
  input  logic                 txMode,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 collision
);

  rxStrobes_t strobes;

  serial_frame_rx_ctrl #(
    .DATA_BITS(DATA_BITS),
    .STOP_BITS(STOP_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .lineIn  (lineIn),
    .strobes (strobes)
  );

  serial_frame_rx_dp #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lineIn    (lineIn),
    .txMode    (txMode),
    .strobes   (strobes),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet),
    .collision (collision)
  );

endmodule

// File: tb/serial_frame_rx_test.sv
`timescale 1ns/1ps
module serial_frame_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lineIn = 1'b1;
  logic       txMode = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, parityErr, frameErr, breakDet, collision;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] lastData = 8'h00;

  always #10 clk = ~clk;   // 50 MHz

  serial_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .txMode(txMode),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .frameErr(frameErr), .breakDet(breakDet), .collision(collision)
  );

  // vector: [16:9] data, [8] parity, [7] stop1, [6] stop2, [5] txMode,
  //         [4:0] expected {valid, parityErr, frameErr, breakDet, collision}
  localparam int NVEC = 16;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 5'b10000},
    {8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 5'b01000},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 5'b00100},
    {8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00100},
    {8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01100},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 5'b10000},
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00100},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00010},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00010},
    {8'h55, 1'b0, 1'b1, 1'b1, 1'b1, 5'b10000},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00001},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00010},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00010},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00010},
    {8'h12, 1'b0, 1'b1, 1'b1, 1'b1, 5'b10000},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00001}
  };

  function automatic logic [4:0] flags();
    return {rxValid, parityErr, frameErr, breakDet, collision};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic driveBit(input logic b);
    lineIn = b;
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic p, input logic s1, input logic s2);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(p);
    driveBit(s1);
    driveBit(s2);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    int evCount;
    int brkCount;
    string tag;
    logic [4:0] exp;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(flags() == 5'b0 && rxData == 8'h00, "R1 in reset", {rxData, 3'b0, flags()}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags() == 5'b0 && rxData == 8'h00, "R1 after reset", {rxData, 3'b0, flags()}, 0);

    // R2 idle high line gives nothing
    evCount = 0;
    for (int i = 0; i < 20; i++) begin
      driveBit(1'b1);
      if (flags() != 5'b0) evCount++;
    end
    check(evCount == 0, "R2 idle high", evCount, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      txMode = VEC[v][5];
      sendFrame(VEC[v][16:9], VEC[v][8], VEC[v][7], VEC[v][6]);
      exp = VEC[v][4:0];
      if (exp[4]) tag = "R3 good frame";
      else if (exp[3] && exp[2]) tag = "R6 both errors";
      else if (exp[3]) tag = "R4 parity";
      else if (exp[2]) tag = "R5 stop";
      else if (exp[1] && VEC[v][5]) tag = "R9 second break";
      else if (exp[1]) tag = "R7 break";
      else tag = "R8 collision";
      check(flags() == exp, tag, flags(), exp);
      if (exp[4]) lastData = VEC[v][16:9];
      check(rxData == lastData, {tag, " data"}, rxData, lastData);
      driveBit(1'b1);
      check(flags() == 5'b0, "R3 one-cycle pulse", flags(), 0);
      driveBit(1'b1);
    end

    // R2 timing: nothing before the 12th bit, result right after it
    txMode = 1'b0;
    evCount = 0;
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) begin
      driveBit(i[0]);             // data 0xAA, four ones
      if (flags() != 5'b0) evCount++;
    end
    driveBit(1'b0);
    if (flags() != 5'b0) evCount++;
    driveBit(1'b1);
    if (flags() != 5'b0) evCount++;
    check(evCount == 0, "R2 early pulse", evCount, 0);
    driveBit(1'b1);
    check(rxValid == 1'b1 && rxData == 8'hAA, "R2 pulse after 12th bit", {rxData, 3'b0, flags()}, {8'hAA, 8'h10});

    // R11 back-to-back frames with no idle gap
    sendFrame(8'h5A, 1'b0, 1'b1, 1'b1);
    check(rxValid && rxData == 8'h5A, "R11 first frame", rxData, 8'h5A);
    sendFrame(8'hC3, 1'b0, 1'b1, 1'b1);
    check(rxValid && rxData == 8'hC3, "R11 second frame", rxData, 8'hC3);
    lastData = 8'hC3;
    driveBit(1'b1);

    // R10 long low line gives only one break
    evCount = 0;
    brkCount = 0;
    for (int i = 0; i < 30; i++) begin
      driveBit(1'b0);
      if (breakDet) brkCount++;
      if (flags() != 5'b0) evCount++;
    end
    for (int i = 0; i < 3; i++) begin
      driveBit(1'b1);
      if (flags() != 5'b0) evCount++;
    end
    check(brkCount == 1 && evCount == 1, "R10 long low single break", {brkCount[15:0], evCount[15:0]}, {16'd1, 16'd1});

    // R10 low after a failed stop bit is not a start
    sendFrame(8'hF0, 1'b0, 1'b1, 1'b0);
    check(frameErr == 1'b1, "R5 stop2 low", flags(), 5'b00100);
    evCount = 0;
    for (int i = 0; i < 15; i++) begin
      driveBit(1'b0);
      if (flags() != 5'b0) evCount++;
    end
    check(evCount == 0, "R10 no restart while low", evCount, 0);
    driveBit(1'b1);
    sendFrame(8'h3E, 1'b1, 1'b1, 1'b1);   // five ones, parity 1
    check(rxValid && rxData == 8'h3E, "R10 recovery", rxData, 8'h3E);
    driveBit(1'b1);

    finish();
  end

endmodule